// File: doc/BRIEF.md
# Two-Wire Bus Link Monitor

This block watches the data and clock lines of a two-wire serial bus and reports when a device plugs onto the bus or drops off it. A link-up is seen when both lines are high at the same time. A link-down is seen when both lines stay low together, without a break, for a programmable number of sample-clock cycles. The time limit keeps the ordinary low periods of bus traffic from being reported. Only one of the two events is armed at a time, and a direction bit in the control register picks which one.

Both line inputs pass through a two-flop synchronizer before they are compared. The qualified event condition is edge-detected, so a state that persists sets the sticky event flag once. The flag is cleared by an interrupt-acknowledge pulse or by a write-one-to-clear. The interrupt request is the flag gated by a local enable bit.

Software normally arms link-up detection first (direction 0). After the flag reports a link-up, it sets the direction bit to 1. This stops the idle bus, where both lines are high, from raising the flag again, and it arms link-down detection.

Top module: `bus_link_monitor`

## Requirements
- R1: After reset the register reads 0x00 and `irq_o` is low.
- R2: With the direction bit at 0, both lines high at the pins sets the flag (register bit 7) on the third rising clock edge after the change, and not before.
- R3: A condition that persists sets the flag only once. A flag cleared while both lines stay high remains clear.
- R4: With the direction bit at 1, both lines high never sets the flag.
- R5: With the direction bit at 1 and delay code 00, both lines low sets the flag on rising edge 3+16 after the lines fall, and not on edge 2+16.
- R6: Delay code (bits 2:1) 01, 10 and 11 select low-time thresholds of 32, 64 and 128 cycles, with the flag due on edge 3+threshold.
- R7: A rise of either line restarts the low-time count from zero.
- R8: One line low while the other stays high never sets the flag, in either direction setting.
- R9: Register layout: bit 7 flag, bit 6 interrupt enable, bits 5:3 read 0 and ignore writes, bits 2:1 delay code, bit 0 direction. A write updates bits 6:0 on the next edge.
- R10: Writing 1 to bit 7 clears the flag. Writing 0 to bit 7 leaves it unchanged.
- R11: A one-cycle `irq_ack_i` pulse clears the flag.
- R12: `irq_o` is high exactly when both the flag and the enable bit are 1.
- R13: If an event sets the flag in the same cycle as a clear by write or by acknowledge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Bus data line, asynchronous |
| scl_i | input | 1 | Bus clock line, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_ack_i | input | 1 | Interrupt serviced, clears the flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change passes two synchronizer edges, and the rise detector adds one more edge. So a link-up flag is due on the third rising edge after the change, and a link-down flag on edge 3+threshold. Register writes and acknowledges take effect on the first edge. The bench drives inputs on falling edges and samples on falling edges. It checks every timed result both one edge early, where the old value is expected, and on the exact due edge. For the count-restart case, the same rule places the due edge a known distance after the glitch.

// File: rtl/blm_pkg.sv
package blm_pkg;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int DLY_LSB  = 1;
  localparam int POL_BIT  = 0;

  typedef struct packed {
    logic       ie;
    logic [1:0] dly;
    logic       pol;  // 0: watch for link-up, 1: watch for link-down
  } ctrl_t;
endpackage

// File: rtl/blm_sync.sv
module blm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/blm_event_qual.sv
module blm_event_qual #(
  parameter int unsigned DLY0 = 16,
  parameter int unsigned DLY1 = 32,
  parameter int unsigned DLY2 = 64,
  parameter int unsigned DLY3 = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_s_i,
  input  logic       scl_s_i,
  input  logic       pol_i,
  input  logic [1:0] dly_i,
  output logic       set_ev_o
);
  localparam int unsigned MAX01 = (DLY0 > DLY1) ? DLY0 : DLY1;
  localparam int unsigned MAX23 = (DLY2 > DLY3) ? DLY2 : DLY3;
  localparam int unsigned MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int          CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAXT);

  logic             both_hi, both_lo;
  logic [CNT_W-1:0] low_cnt_q, thr;
  logic             cond, cond_q;

  assign both_hi = sda_s_i & scl_s_i;
  assign both_lo = ~sda_s_i & ~scl_s_i;

  always_comb begin
    unique case (dly_i)
      2'd0:    thr = CNT_W'(DLY0);
      2'd1:    thr = CNT_W'(DLY1);
      2'd2:    thr = CNT_W'(DLY2);
      default: thr = CNT_W'(DLY3);
    endcase
  end

  // count consecutive both-low cycles, saturating at the largest threshold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                low_cnt_q <= '0;
    else if (!both_lo)          low_cnt_q <= '0;
    else if (low_cnt_q != CNT_SAT) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign cond = pol_i ? (low_cnt_q >= thr) : both_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b0;
    else         cond_q <= cond;
  end

  assign set_ev_o = cond & ~cond_q;
endmodule

// File: rtl/blm_ctrl_reg.sv
module blm_ctrl_reg
  import blm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  wdata_i,
  input  logic        set_ev_i,
  input  logic        ack_i,
  output logic [7:0]  rdata_o,
  output ctrl_t       ctrl_o,
  output logic        irq_o
);
  ctrl_t ctrl_q;
  logic  flag_q;
  logic  unused_wdata;

  assign unused_wdata = ^wdata_i[5:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.ie  <= wdata_i[IE_BIT];
      ctrl_q.dly <= wdata_i[DLY_LSB +: 2];
      ctrl_q.pol <= wdata_i[POL_BIT];
    end
  end

  // set has priority over both clear sources
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                flag_q <= 1'b0;
    else if (set_ev_i)                          flag_q <= 1'b1;
    else if (ack_i || (we_i && wdata_i[FLAG_BIT])) flag_q <= 1'b0;
  end

  assign rdata_o = {flag_q, ctrl_q.ie, 3'b000, ctrl_q.dly, ctrl_q.pol};
  assign ctrl_o  = ctrl_q;
  assign irq_o   = flag_q & ctrl_q.ie;
endmodule

// File: rtl/bus_link_monitor.sv
module bus_link_monitor
  import blm_pkg::*;
#(
  parameter int unsigned DLY0 = 16,
  parameter int unsigned DLY1 = 32,
  parameter int unsigned DLY2 = 64,
  parameter int unsigned DLY3 = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       irq_ack_i,
  output logic       irq_o
);
  logic [1:0] line_s;
  logic       set_ev;
  ctrl_t      ctrl;

  blm_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sda_i, scl_i}),
    .q_o    (line_s)
  );

  blm_event_qual #(.DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sda_s_i  (line_s[1]),
    .scl_s_i  (line_s[0]),
    .pol_i    (ctrl.pol),
    .dly_i    (ctrl.dly),
    .set_ev_o (set_ev)
  );

  blm_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .set_ev_i (set_ev),
    .ack_i    (irq_ack_i),
    .rdata_o  (reg_rdata_o),
    .ctrl_o   (ctrl),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/blm_checker.sv
module blm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_ack_i,
  input logic       irq_o,
  input logic       set_ev
);
  a_r12_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (reg_rdata_o[7] & reg_rdata_o[6]));

  a_r9_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[5:3] == 3'b000);

  a_r13_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> reg_rdata_o[7]);

  a_r10_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[7] && !set_ev) |=> !reg_rdata_o[7]);

  a_r10_w0_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[7] && !irq_ack_i && !(reg_we_i && reg_wdata_i[7])) |=> reg_rdata_o[7]);

  a_r11_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !set_ev) |=> !reg_rdata_o[7]);

  a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[7] && !set_ev) |=> !reg_rdata_o[7]);
endmodule

bind bus_link_monitor blm_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_ack_i   (irq_ack_i),
  .irq_o       (irq_o),
  .set_ev      (set_ev)
);

// File: tb/sim_bus_link_monitor.sv
module sim_bus_link_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sda = 1'b1, scl = 1'b0;
  logic       we = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bus_link_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_i(scl),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_ack_i(ack), .irq_o(irq)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    we = 1'b1; wdata = d;
    step(1);
    we = 1'b0; wdata = 8'h00;
  endtask

  task automatic do_reset();
    sda = 1'b1; scl = 1'b0; we = 1'b0; ack = 1'b0;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reg", rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_connect();
    do_reset();
    scl = 1'b1;
    step(2);
    chk("R2 early", {7'd0, rdata[7]}, 8'h00);
    step(1);
    chk("R2 due", {7'd0, rdata[7]}, 8'h01);
    chk("R12 ie0", {7'd0, irq}, 8'h00);
    wr(8'h40);
    chk("R12 ie1", {7'd0, irq}, 8'h01);
    wr(8'hC0);
    chk("R10 w1c", {7'd0, rdata[7]}, 8'h00);
    step(10);
    chk("R3 once", {7'd0, rdata[7]}, 8'h00);
    chk("R12 off", {7'd0, irq}, 8'h00);
    scl = 1'b0; step(3); scl = 1'b1; step(3);
    chk("R2 again", {7'd0, rdata[7]}, 8'h01);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R11 ack", {7'd0, rdata[7]}, 8'h00);
    scl = 1'b0; step(3); scl = 1'b1; step(3);
    wr(8'h40);
    chk("R10 w0", {7'd0, rdata[7]}, 8'h01);
  endtask

  task automatic t_disconnect();
    do_reset();
    wr(8'h01);
    scl = 1'b1;
    step(10);
    chk("R4 no link-up", {7'd0, rdata[7]}, 8'h00);
    sda = 1'b0; scl = 1'b0;
    step(18);
    chk("R5 early", {7'd0, rdata[7]}, 8'h00);
    step(1);
    chk("R5 due", {7'd0, rdata[7]}, 8'h01);
    chk("R9 layout", rdata, 8'h81);
  endtask

  task automatic t_codes();
    for (int c = 1; c < 4; c++) begin
      int thr = 16 << c;
      do_reset();
      wr(8'((c << 1) | 1));
      sda = 1'b0; scl = 1'b0;
      step(2 + thr);
      chk("R6 early", {7'd0, rdata[7]}, 8'h00);
      step(1);
      chk("R6 due", {7'd0, rdata[7]}, 8'h01);
    end
  endtask

  task automatic t_restart();
    do_reset();
    wr(8'h01);
    sda = 1'b0; scl = 1'b0;
    step(12);
    sda = 1'b1; step(1); sda = 1'b0;
    step(18);
    chk("R7 early", {7'd0, rdata[7]}, 8'h00);
    step(1);
    chk("R7 due", {7'd0, rdata[7]}, 8'h01);
  endtask

  task automatic t_single_low();
    do_reset();
    wr(8'h01);
    sda = 1'b0; scl = 1'b1;
    step(200);
    chk("R8 sda low", {7'd0, rdata[7]}, 8'h00);
    sda = 1'b1; scl = 1'b0;
    step(200);
    chk("R8 scl low", {7'd0, rdata[7]}, 8'h00);
    wr(8'h00);
    sda = 1'b0; scl = 1'b1;
    step(50);
    chk("R8 dir0", {7'd0, rdata[7]}, 8'h00);
  endtask

  task automatic t_fields();
    do_reset();
    wr(8'h7E);
    chk("R9 ro zero", rdata, 8'h46);
    wr(8'h00);
    chk("R9 clear", rdata, 8'h00);
  endtask

  task automatic t_set_wins();
    do_reset();
    scl = 1'b1;
    step(2);
    we = 1'b1; wdata = 8'h80; ack = 1'b1;
    step(1);
    we = 1'b0; wdata = 8'h00; ack = 1'b0;
    chk("R13 set wins", {7'd0, rdata[7]}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_connect();
    t_disconnect();
    t_codes();
    t_restart();
    t_single_low();
    t_fields();
    t_set_wins();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule